// File: doc/BRIEF.md
# Operand Location Map with Producer Tags

This block is the architectural-to-physical lookup of an out-of-order core. It keeps one word per architectural register, and that word says where the register's newest value lives. When the value already sits in the register file, the word holds a physical register number. When the value is still being computed, the word names the functional unit that will deliver it and the tag that unit will broadcast. A scheduler reads a source register and gets back either a register-file location or a unit and tag to watch.

The decode stage marks each destination as awaited through the rename write port. Completing units announce a unit and tag together with the physical register that now holds the result, and every entry waiting on that unit and tag becomes ready. Physical register allocation and free lists belong to neighbouring blocks.

Each word is 8 bits. The top bit is the state bit. The remaining 7 bits hold either a physical register number or a unit and tag packed into the same positions.

Top module: `srcloc_table`

## Requirements
- R1: Each entry is 8 bits. Bit 7 set means the value is in the register file and bits 6:0 are its physical register number. Bit 7 clear means the value is awaited: bits 6:4 hold the unit ID and bits 3:0 hold the tag.
- R2: After reset, all 32 entries are ready and architectural register i maps to physical register i.
- R3: Each read port decodes the stored entry of its address combinationally. Ready gives rd_ready=1, the register number on rd_prn, and zero on rd_unit and rd_tag. Pending gives rd_ready=0, the unit and tag, and zero on rd_prn. The two ports are independent.
- R4: A rename write takes effect on the next clock edge and makes the entry pending on the given unit and tag. A read in the same cycle still returns the old entry.
- R5: A broadcast that matches both the unit and the tag of pending entries makes every such entry ready on the next edge, holding the broadcast physical register number.
- R6: A broadcast leaves unchanged any pending entry whose unit or tag differs, even when one of the two fields matches.
- R7: A broadcast never changes a ready entry, even when the entry's register-number bits equal the broadcast unit and tag pattern.
- R8: When a rename write and a matching broadcast hit the same entry in the same cycle, the rename wins. Other matching entries still become ready.
- R9: With ren_valid and bc_valid low, no entry changes, whatever values the other write and broadcast inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | NUM_READ x 5 | Architectural register for each read port |
| rd_ready | output | NUM_READ | Entry is in the register file |
| rd_prn | output | NUM_READ x 7 | Physical register number (zero when pending) |
| rd_unit | output | NUM_READ x 3 | Producing unit (zero when ready) |
| rd_tag | output | NUM_READ x 4 | Producer tag (zero when ready) |
| ren_valid | input | 1 | Rename write strobe |
| ren_arch | input | 5 | Destination architectural register |
| ren_unit | input | 3 | Unit that will produce the value |
| ren_tag | input | 4 | Tag the unit will broadcast |
| bc_valid | input | 1 | Result broadcast strobe |
| bc_unit | input | 3 | Broadcasting unit |
| bc_tag | input | 4 | Broadcast tag |
| bc_prn | input | 7 | Physical register now holding the result |

## Verification
Reads are combinational, so a read result is due in the same cycle as the address. The bench sets the address after a falling edge and samples a short delay later. Rename and broadcast updates land on the next rising edge, which is one register stage. The bench drives them after a falling edge and reads the effect after the following falling edge. It also reads once before that edge, which confirms that a same-cycle read still returns the old entry. Every expected value comes from a bench-side model of the 32 words, updated with the requirement rules after each edge.

// File: rtl/srcloc_pkg.sv
package srcloc_pkg;
  localparam int PRN_W  = 7;
  localparam int UNIT_W = 3;
  localparam int TAG_W  = 4;
  localparam int ENT_W  = 1 + PRN_W;

  typedef logic [ENT_W-1:0] slot_t;

  // ready word: state bit set, register number below it
  function automatic slot_t home_word(input logic [PRN_W-1:0] prn);
    return {1'b1, prn};
  endfunction

  // pending word: state bit clear, unit over tag
  function automatic slot_t wait_word(input logic [UNIT_W-1:0] u, input logic [TAG_W-1:0] t);
    return {1'b0, u, t};
  endfunction

  function automatic logic waits_on(input slot_t w, input logic [UNIT_W-1:0] u,
                                    input logic [TAG_W-1:0] t);
    return !w[ENT_W-1] && (w[PRN_W-1:0] == {u, t});
  endfunction
endpackage

// File: rtl/srcloc_cell.sv
module srcloc_cell
  import srcloc_pkg::*;
#(
  parameter int INIT_PRN = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_hit,
  input  slot_t             ren_word,
  input  logic              bc_valid,
  input  logic [UNIT_W-1:0] bc_unit,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [PRN_W-1:0]  bc_prn,
  output slot_t             word_q,
  output logic              wake_hit
);
  assign wake_hit = bc_valid && waits_on(word_q, bc_unit, bc_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= home_word(PRN_W'(INIT_PRN));
    else if (ren_hit)  word_q <= ren_word;
    else if (wake_hit) word_q <= home_word(bc_prn);
  end
endmodule

// File: rtl/srcloc_rdport.sv
module srcloc_rdport
  import srcloc_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  localparam int AW = $clog2(NUM_ARCH)
) (
  input  slot_t [NUM_ARCH-1:0] tbl,
  input  logic  [AW-1:0]       addr,
  output logic                 ready,
  output logic  [PRN_W-1:0]    prn,
  output logic  [UNIT_W-1:0]   unit,
  output logic  [TAG_W-1:0]    tag
);
  slot_t sel;
  assign sel   = tbl[addr];
  assign ready = sel[ENT_W-1];
  assign prn   = ready ? sel[PRN_W-1:0] : '0;
  assign unit  = ready ? '0 : sel[PRN_W-1:TAG_W];
  assign tag   = ready ? '0 : sel[TAG_W-1:0];
endmodule

// File: rtl/srcloc_table.sv
module srcloc_table
  import srcloc_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_READ = 2,
  localparam int AW = $clog2(NUM_ARCH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_READ-1:0][AW-1:0]      rd_addr,
  output logic [NUM_READ-1:0]              rd_ready,
  output logic [NUM_READ-1:0][PRN_W-1:0]   rd_prn,
  output logic [NUM_READ-1:0][UNIT_W-1:0]  rd_unit,
  output logic [NUM_READ-1:0][TAG_W-1:0]   rd_tag,
  input  logic                             ren_valid,
  input  logic [AW-1:0]                    ren_arch,
  input  logic [UNIT_W-1:0]                ren_unit,
  input  logic [TAG_W-1:0]                 ren_tag,
  input  logic                             bc_valid,
  input  logic [UNIT_W-1:0]                bc_unit,
  input  logic [TAG_W-1:0]                 bc_tag,
  input  logic [PRN_W-1:0]                 bc_prn
);
  // named internal events for the checker
  slot_t [NUM_ARCH-1:0] tbl_q;
  logic  [NUM_ARCH-1:0] ren_hit;
  logic  [NUM_ARCH-1:0] wake_hit;
  slot_t                ren_word;

  assign ren_word = wait_word(ren_unit, ren_tag);

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_cell
    assign ren_hit[i] = ren_valid && (ren_arch == AW'(i));
    srcloc_cell #(.INIT_PRN(i)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ren_hit (ren_hit[i]),
      .ren_word(ren_word),
      .bc_valid(bc_valid),
      .bc_unit (bc_unit),
      .bc_tag  (bc_tag),
      .bc_prn  (bc_prn),
      .word_q  (tbl_q[i]),
      .wake_hit(wake_hit[i])
    );
  end

  for (genvar r = 0; r < NUM_READ; r++) begin : g_rd
    srcloc_rdport #(.NUM_ARCH(NUM_ARCH)) u_rd (
      .tbl  (tbl_q),
      .addr (rd_addr[r]),
      .ready(rd_ready[r]),
      .prn  (rd_prn[r]),
      .unit (rd_unit[r]),
      .tag  (rd_tag[r])
    );
  end
endmodule

// File: rtl/srcloc_table_chk.sv
module srcloc_table_chk
  import srcloc_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_READ = 2,
  localparam int AW = $clog2(NUM_ARCH)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_READ-1:0][AW-1:0]     rd_addr,
  input logic [NUM_READ-1:0]             rd_ready,
  input logic [NUM_READ-1:0][PRN_W-1:0]  rd_prn,
  input logic [NUM_READ-1:0][UNIT_W-1:0] rd_unit,
  input logic [NUM_READ-1:0][TAG_W-1:0]  rd_tag,
  input logic                            ren_valid,
  input logic [AW-1:0]                   ren_arch,
  input logic [UNIT_W-1:0]               ren_unit,
  input logic [TAG_W-1:0]                ren_tag,
  input logic                            bc_valid,
  input logic [UNIT_W-1:0]               bc_unit,
  input logic [TAG_W-1:0]                bc_tag,
  input logic [PRN_W-1:0]                bc_prn,
  input slot_t [NUM_ARCH-1:0]            tbl_q,
  input logic [NUM_ARCH-1:0]             wake_hit
);
  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
    // R4 R8
    rename_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && ren_arch == AW'(i)) |=>
        (tbl_q[i] == {1'b0, $past(ren_unit), $past(ren_tag)}));
    // R5
    wake_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !tbl_q[i][ENT_W-1] && tbl_q[i][PRN_W-1:0] == {bc_unit, bc_tag}
       && !(ren_valid && ren_arch == AW'(i))) |=>
        (tbl_q[i] == {1'b1, $past(bc_prn)}));
    // R6 R9
    untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ren_valid && ren_arch == AW'(i)) &&
       !(bc_valid && !tbl_q[i][ENT_W-1] && tbl_q[i][PRN_W-1:0] == {bc_unit, bc_tag}))
        |=> $stable(tbl_q[i]));
    // R7
    ready_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_q[i][ENT_W-1] |-> !wake_hit[i]);
  end

  for (genvar r = 0; r < NUM_READ; r++) begin : g_port
    // R1 R3
    read_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready[r] ? (rd_unit[r] == '0 && rd_tag[r] == '0 &&
                     tbl_q[rd_addr[r]] == {1'b1, rd_prn[r]})
                  : (rd_prn[r] == '0 &&
                     tbl_q[rd_addr[r]] == {1'b0, rd_unit[r], rd_tag[r]}));
  end
endmodule

bind srcloc_table srcloc_table_chk #(.NUM_ARCH(NUM_ARCH), .NUM_READ(NUM_READ)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_prn(rd_prn),
  .rd_unit(rd_unit), .rd_tag(rd_tag), .ren_valid(ren_valid), .ren_arch(ren_arch),
  .ren_unit(ren_unit), .ren_tag(ren_tag), .bc_valid(bc_valid), .bc_unit(bc_unit),
  .bc_tag(bc_tag), .bc_prn(bc_prn), .tbl_q(tbl_q), .wake_hit(wake_hit)
);

// File: tb/sim_srcloc_table.sv
`timescale 1ns/1ps
module sim_srcloc_table;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0][4:0]  rd_addr = '0;
  logic [1:0]       rd_ready;
  logic [1:0][6:0]  rd_prn;
  logic [1:0][2:0]  rd_unit;
  logic [1:0][3:0]  rd_tag;
  logic             ren_valid = 1'b0;
  logic [4:0]       ren_arch = '0;
  logic [2:0]       ren_unit = '0;
  logic [3:0]       ren_tag = '0;
  logic             bc_valid = 1'b0;
  logic [2:0]       bc_unit = '0;
  logic [3:0]       bc_tag = '0;
  logic [6:0]       bc_prn = '0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [32];

  always #10 clk = ~clk;

  srcloc_table u0 (.*);

  task automatic chk_read(input int port, input int arch, input string req);
    logic       e_rdy;
    logic [6:0] e_prn;
    logic [2:0] e_unit;
    logic [3:0] e_tag;
    rd_addr[port] = 5'(arch);
    #1;
    e_rdy  = model[arch][7];
    e_prn  = e_rdy ? model[arch][6:0] : 7'd0;
    e_unit = e_rdy ? 3'd0 : model[arch][6:4];
    e_tag  = e_rdy ? 4'd0 : model[arch][3:0];
    checks++;
    if (rd_ready[port] !== e_rdy || rd_prn[port] !== e_prn ||
        rd_unit[port] !== e_unit || rd_tag[port] !== e_tag) begin
      fails++;
      $display("FAIL %s port%0d arch%0d: got rdy=%0b prn=%0d unit=%0d tag=%0d exp rdy=%0b prn=%0d unit=%0d tag=%0d",
               req, port, arch, rd_ready[port], rd_prn[port], rd_unit[port], rd_tag[port],
               e_rdy, e_prn, e_unit, e_tag);
    end
  endtask

  // drive after a falling edge; update lands on the next rising edge
  task automatic drive(input bit rv, input int ra, input int ru, input int rt,
                       input bit bv, input int bu, input int bt, input int bp);
    ren_valid = rv; ren_arch = 5'(ra); ren_unit = 3'(ru); ren_tag = 4'(rt);
    bc_valid = bv; bc_unit = 3'(bu); bc_tag = 4'(bt); bc_prn = 7'(bp);
  endtask

  task automatic settle(input bit rv, input int ra, input int ru, input int rt,
                        input bit bv, input int bu, input int bt, input int bp);
    logic [7:0] nxt [32];
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      nxt[i] = model[i];
      if (bv && model[i] == {1'b0, 3'(bu), 4'(bt)}) nxt[i] = {1'b1, 7'(bp)};
    end
    if (rv) nxt[ra] = {1'b0, 3'(ru), 4'(rt)};
    for (int i = 0; i < 32; i++) model[i] = nxt[i];
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic op(input bit rv, input int ra, input int ru, input int rt,
                    input bit bv, input int bu, input int bt, input int bp);
    drive(rv, ra, ru, rt, bv, bu, bt, bp);
    settle(rv, ra, ru, rt, bv, bu, bt, bp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 32; a++) begin
      chk_read(0, a, "R2");
      chk_read(1, 31 - a, "R3");
    end
  endtask

  task automatic t_rename();
    drive(1, 5, 3, 9, 0, 0, 0, 0);
    chk_read(0, 5, "R4");             // old value still visible
    settle(1, 5, 3, 9, 0, 0, 0, 0);
    chk_read(0, 5, "R1");             // pending unit 3 tag 9
    chk_read(1, 5, "R3");
  endtask

  task automatic t_wake();
    op(1, 7, 2, 4, 0, 0, 0, 0);
    op(1, 12, 2, 4, 0, 0, 0, 0);
    op(1, 8, 2, 5, 0, 0, 0, 0);
    op(1, 9, 6, 4, 0, 0, 0, 0);
    op(0, 0, 0, 0, 1, 2, 4, 100);
    chk_read(0, 7, "R5");
    chk_read(1, 12, "R5");
    chk_read(0, 8, "R6");
    chk_read(1, 9, "R6");
    chk_read(0, 5, "R6");
  endtask

  task automatic t_ready_immune();
    // arch 20 holds prn 20 = 7'b001_0100, same bits as unit 1 tag 4
    op(1, 21, 1, 4, 0, 0, 0, 0);
    op(0, 0, 0, 0, 1, 1, 4, 77);
    chk_read(0, 20, "R7");
    chk_read(1, 21, "R5");
  endtask

  task automatic t_collide();
    op(1, 3, 5, 1, 0, 0, 0, 0);
    op(1, 4, 5, 1, 0, 0, 0, 0);
    op(1, 3, 0, 15, 1, 5, 1, 60);
    chk_read(0, 3, "R8");
    chk_read(1, 4, "R8");
  endtask

  task automatic t_idle();
    op(0, 8, 7, 7, 0, 2, 5, 99);
    chk_read(0, 8, "R9");
    chk_read(1, 9, "R9");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = {1'b1, 7'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rename();
    t_wake();
    t_ready_immune();
    t_collide();
    t_idle();
    for (int a = 0; a < 32; a++) chk_read(a % 2, a, "R3");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule